// File: doc/BRIEF.md
# Cascadable Column-Driver Line Latch

This block is the input stage of a display column driver. It captures a line of pixel levels into a 384-slot buffer, six bits per slot. On each data-clock edge during capture it takes six 6-bit samples, which are two RGB pixels, and writes them into six neighbouring slots. A start token on the selected enable input begins a capture run of exactly 64 beats. Near the end of the run the stage passes the token on through its enable output, then enters standby and ignores the data bus.

Stages are chained by wiring each token output to the token input of the next stage. The token is raised one beat before the last capture, so the next stage begins capturing on the beat right after this one finishes, with no gap. A line-load strobe, sampled on the data clock, copies the whole buffer into the hold register that drives the column outputs, drops the token and returns a stage in standby to idle. A direction input chooses which enable pair is used and whether the buffer fills from the low or the high end.

The sequencer has three states. `ST_IDLE` waits for a start. `ST_FILL` captures one beat per clock. `ST_STANDBY` waits for the line load. Its transitions are START (IDLE→FILL on a sampled start), LAST_BEAT (FILL→STANDBY on the 64th capture) and LOAD (STANDBY→IDLE on line load).

Top module: `cdl_latch_stage`

## Requirements
- R1: The start input is sampled on a rising clock edge. The first capture happens on the next rising edge, and data present on the sampling edge itself is not stored.
- R2: Each capture edge stores the six samples at once. Sample i is `pix_in[6i+5:6i]`. With `dir_up`=1, capture k (counting from 0) writes slot 6k+i, which is `drive_level[6s+5:6s]` for slot s.
- R3: A run is exactly 64 capture edges. Afterwards the stage is in standby, and data on `pix_in` has no effect on the line that is later loaded.
- R4: The active token output rises after the 64th edge counted from the sampling edge, which is the 63rd capture. It stays high until a line load. A next stage fed by it captures the beats that follow this stage's last capture, with no gap.
- R5: A start pulse that arrives during a fill or during standby is ignored. It does not change the token timing or the stored data.
- R6: A line load copies the buffer into `drive_level` and clears both token outputs, both visible after that edge. Without a line load, `drive_level` does not change.
- R7: With `dir_up`=1, `left_en_in` starts the stage and `right_en_out` carries the token. With `dir_up`=0, `right_en_in` starts it, `left_en_out` carries the token, and capture k writes slot 383-(6k+i). The unused token output stays low.
- R8: While `rst` is high, the sequencer goes idle and both token outputs read low after the next edge.
- R9: After a line load, a stage that completed a run accepts a new start and captures a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all capture and loading on its rising edge |
| rst | input | 1 | Synchronous reset of sequencer and token |
| dir_up | input | 1 | 1: fill from slot 0 upward, start on left; 0: mirrored |
| left_en_in | input | 1 | Start token input when `dir_up`=1 |
| right_en_in | input | 1 | Start token input when `dir_up`=0 |
| line_load | input | 1 | Copy buffer to outputs and clear token |
| pix_in | input | 36 | Six 6-bit samples per beat |
| left_en_out | output | 1 | Token output when `dir_up`=0 |
| right_en_out | output | 1 | Token output when `dir_up`=1 |
| drive_level | output | 2304 | Held 6-bit level for each of 384 columns |

## Verification
Two stages are chained in the bench, so the token's early rise is checked where it matters. If the token rose one beat late, the second stage would lose a beat and its loaded line would be shifted. If it rose one beat early, the last beat of the first stage would be captured twice. Garbage is driven on the sampling edge and after the run. A stage that captured on the sampling edge, or that kept writing in standby, would show corrupted slots. Extra start pulses are sent both mid-fill and in standby, where a stage that restarted would rewrite its buffer. Both directions are run, so a fill order that is mirrored within each group but not across groups, or the reverse, fails the slot-by-slot comparison.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

    localparam int unsigned DEF_SLOTS = 384;
    localparam int unsigned DEF_BITS  = 6;
    localparam int unsigned DEF_LANES = 6;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FILL    = 2'd1,
        ST_STANDBY = 2'd2
    } cdl_state_e;

endpackage

// File: rtl/cdl_sequencer.sv
module cdl_sequencer
    import cdl_pkg::*;
#(
    parameter int unsigned GROUPS = 64,
    parameter int unsigned GW     = $clog2(GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          line_load,
    output logic          wr_en,
    output logic [GW-1:0] wr_grp,
    output logic          tok_out
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);
    localparam logic [GW-1:0] PRE_LAST = GW'(GROUPS - 2);

    cdl_state_e    state_q;
    cdl_state_e    state_d;
    logic [GW-1:0] grp_q;
    logic          tok_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)              state_d = ST_FILL;     // START
            ST_FILL:    if (grp_q == LAST_GRP)  state_d = ST_STANDBY;  // LAST_BEAT
            ST_STANDBY: if (line_load)          state_d = ST_IDLE;     // LOAD
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // beat pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
        end else if (state_q == ST_FILL) begin
            grp_q <= (grp_q == LAST_GRP) ? '0 : grp_q + 1'b1;
        end else begin
            grp_q <= '0;
        end
    end

    // token: raised one beat before the last capture, cleared by line load
    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= 1'b0;
        end else if (line_load) begin
            tok_q <= 1'b0;
        end else if (state_q == ST_FILL && grp_q == PRE_LAST) begin
            tok_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    wr_en = 1'b0;
            ST_FILL:    wr_en = 1'b1;
            ST_STANDBY: wr_en = 1'b0;
            default:    wr_en = 1'b0;
        endcase
    end

    assign wr_grp  = grp_q;
    assign tok_out = tok_q;

endmodule

// File: rtl/cdl_line_buffer.sv
module cdl_line_buffer #(
    parameter int unsigned GROUPS = 64,
    parameter int unsigned LANES  = 6,
    parameter int unsigned BITS   = 6,
    parameter int unsigned GW     = $clog2(GROUPS)
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic                           dir_up,
    input  logic [GW-1:0]                  wr_grp,
    input  logic [LANES*BITS-1:0]          samples,
    output logic [GROUPS*LANES*BITS-1:0]   line_q
);

    localparam int unsigned GB = LANES * BITS;

    logic [GW-1:0] phys_grp;
    logic [GB-1:0] ordered;

    // mirrored fill: last group first, lanes reversed inside the group
    assign phys_grp = dir_up ? wr_grp : (GW'(GROUPS - 1) - wr_grp);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ordered[l*BITS +: BITS] = dir_up ? samples[l*BITS +: BITS]
                                                : samples[(LANES-1-l)*BITS +: BITS];
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < GROUPS; g++) begin
            if (wr_en && phys_grp == GW'(g)) begin
                line_q[g*GB +: GB] <= ordered;
            end
        end
    end

endmodule

// File: rtl/cdl_hold_reg.sv
module cdl_hold_reg #(
    parameter int unsigned W = 2304
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (load) q <= d;
    end

endmodule

// File: rtl/cdl_latch_stage.sv
module cdl_latch_stage
    import cdl_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned BITS  = DEF_BITS,
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dir_up,
    input  logic                    left_en_in,
    input  logic                    right_en_in,
    input  logic                    line_load,
    input  logic [LANES*BITS-1:0]   pix_in,
    output logic                    left_en_out,
    output logic                    right_en_out,
    output logic [SLOTS*BITS-1:0]   drive_level
);

    localparam int unsigned GROUPS = SLOTS / LANES;
    localparam int unsigned GW     = $clog2(GROUPS);
    localparam int unsigned LINE_W = SLOTS * BITS;

    logic              start_sel;
    logic              wr_en;
    logic [GW-1:0]     wr_grp;
    logic              tok;
    logic [LINE_W-1:0] line_buf;

    assign start_sel = dir_up ? left_en_in : right_en_in;

    cdl_sequencer #(.GROUPS(GROUPS), .GW(GW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_sel),
        .line_load (line_load),
        .wr_en     (wr_en),
        .wr_grp    (wr_grp),
        .tok_out   (tok)
    );

    cdl_line_buffer #(.GROUPS(GROUPS), .LANES(LANES), .BITS(BITS), .GW(GW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .dir_up  (dir_up),
        .wr_grp  (wr_grp),
        .samples (pix_in),
        .line_q  (line_buf)
    );

    cdl_hold_reg #(.W(LINE_W)) u_hold (
        .clk  (clk),
        .load (line_load),
        .d    (line_buf),
        .q    (drive_level)
    );

    assign right_en_out = dir_up & tok;
    assign left_en_out  = ~dir_up & tok;

endmodule

// File: rtl/cdl_latch_stage_sva.sv
module cdl_latch_stage_sva #(
    parameter int unsigned GROUPS = 64,
    parameter int unsigned LINE_W = 2304
) (
    input logic              clk,
    input logic              rst,
    input logic              dir_up,
    input logic              left_en_in,
    input logic              right_en_in,
    input logic              line_load,
    input logic              left_en_out,
    input logic              right_en_out,
    input logic              wr_en,
    input logic [LINE_W-1:0] drive_level
);

    localparam int unsigned CW = $clog2(GROUPS + 1);

    logic [CW-1:0] run_cnt;
    logic          tok_any;
    logic          start_any;

    assign tok_any   = left_en_out | right_en_out;
    assign start_any = dir_up ? left_en_in : right_en_in;

    always_ff @(posedge clk) begin
        if (rst)        run_cnt <= '0;
        else if (wr_en) run_cnt <= run_cnt + 1'b1;
        else            run_cnt <= '0;
    end

    AST_FILL_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(start_any)); // R1

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en) |-> run_cnt == CW'(GROUPS)); // R3

    AST_TOKEN_EARLY_BEAT: assert property (@(posedge clk) disable iff (rst)
        $rose(tok_any) |-> run_cnt == CW'(GROUPS - 1)); // R4

    AST_LOAD_DROPS_TOKEN: assert property (@(posedge clk) disable iff (rst)
        line_load |=> !tok_any); // R6

    AST_HOLD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(line_load) |-> $stable(drive_level)); // R6

    AST_RESET_TOKEN_LOW: assert property (@(posedge clk)
        rst |=> !tok_any); // R8

endmodule

bind cdl_latch_stage cdl_latch_stage_sva #(.GROUPS(GROUPS), .LINE_W(LINE_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .dir_up       (dir_up),
    .left_en_in   (left_en_in),
    .right_en_in  (right_en_in),
    .line_load    (line_load),
    .left_en_out  (left_en_out),
    .right_en_out (right_en_out),
    .wr_en        (wr_en),
    .drive_level  (drive_level)
);

// File: tb/cdl_latch_stage_bench.sv
module cdl_latch_stage_bench;

    localparam int SLOTS = 384;
    localparam int BITS  = 6;
    localparam int LANES = 6;
    localparam int W     = SLOTS * BITS;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  dir_up = 1'b1;
    logic                  a_left_in = 1'b0;
    logic                  a_right_in = 1'b0;
    logic                  line_load = 1'b0;
    logic [LANES*BITS-1:0] pix = '0;
    logic                  a_lo, a_ro, b_lo, b_ro;
    logic [W-1:0]          level_a, level_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cdl_latch_stage u_cdl_latch_stage (
        .clk (clk), .rst (rst), .dir_up (dir_up),
        .left_en_in (a_left_in), .right_en_in (a_right_in),
        .line_load (line_load), .pix_in (pix),
        .left_en_out (a_lo), .right_en_out (a_ro), .drive_level (level_a)
    );

    // second stage of the chain, fed by the first stage's token
    cdl_latch_stage u_cdl_latch_stage_next (
        .clk (clk), .rst (rst), .dir_up (dir_up),
        .left_en_in (a_ro), .right_en_in (a_lo),
        .line_load (line_load), .pix_in (pix),
        .left_en_out (b_lo), .right_en_out (b_ro), .drive_level (level_b)
    );

    function automatic logic [5:0] val(int seed, int k, int i);
        return 6'((seed * 13 + k * 7 + i * 11 + (k >> 3)) & 63);
    endfunction

    function automatic logic [5:0] exp_slot(bit up, int seed, int base, int s);
        int t;
        t = up ? s : SLOTS - 1 - s;
        return val(seed, base + t / LANES, t % LANES);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_line(string req, string what, logic [W-1:0] lv,
                                bit up, int seed, int base);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int s = 0; s < SLOTS; s++) begin
            if (lv[s*BITS +: BITS] !== exp_slot(up, seed, base, s)) begin
                if (bad == 0) begin
                    first_act = int'(lv[s*BITS +: BITS]);
                    first_exp = int'(exp_slot(up, seed, base, s));
                end
                bad++;
            end
        end
        check(bad == 0, req, what, first_act, first_exp);
    endtask

    // one full line through both chained stages
    task automatic run_chain(bit up, int seed, int extra_c);
        logic [W-1:0] snap;
        int err_a = 0, err_b = 0, side = 0;
        bit st;
        @(negedge clk);
        dir_up = up;
        snap = level_a;
        for (int c = 0; c < 132; c++) begin
            @(negedge clk);
            st = (c == 0) || (c == extra_c) || (c == 100);
            a_left_in  = up ? st : 1'b0;
            a_right_in = up ? 1'b0 : st;
            for (int i = 0; i < LANES; i++) begin
                if (c >= 1 && c <= 128) pix[i*BITS +: BITS] = val(seed, c - 1, i);
                else                    pix[i*BITS +: BITS] = ~val(seed, 0, i);
            end
            @(posedge clk);
            #1;
            if ((up ? a_ro : a_lo) !== (c >= 63))  err_a++;
            if ((up ? b_ro : b_lo) !== (c >= 127)) err_b++;
            if ((up ? a_lo : a_ro) !== 1'b0 || (up ? b_lo : b_ro) !== 1'b0) side++;
        end
        check(err_a == 0, "R4", "token rise on 63rd capture, stage 1", err_a, 0);
        check(err_b == 0, "R4", "token rise timing, chained stage", err_b, 0);
        check(side == 0, "R7", "unused token output stays low", side, 0);
        check(level_a === snap, "R6", "outputs unchanged without line load", 0, 0);
        @(negedge clk);
        a_left_in = 1'b0; a_right_in = 1'b0; line_load = 1'b1;
        @(posedge clk);
        #1;
        check({a_lo, a_ro, b_lo, b_ro} == 4'b0, "R6", "tokens cleared by line load",
              {a_lo, a_ro, b_lo, b_ro}, 0);
        // R1 R2 R3 R5: stage 1 holds captures 0..63 only
        compare_line("R2", "stage 1 loaded line", level_a, up, seed, 0);
        compare_line("R4", "chained stage line without gap", level_b, up, seed, 64);
        @(negedge clk);
        line_load = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check({a_lo, a_ro, b_lo, b_ro} == 4'b0, "R8", "token outputs in reset",
              {a_lo, a_ro, b_lo, b_ro}, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fill_up;
        run_chain(1'b1, 1, -1);          // R7 ascending, standby poke for R5
    endtask

    task automatic t_fill_down_restart_pulse;
        run_chain(1'b0, 2, 20);          // R7 mirrored, mid-fill start R5
    endtask

    task automatic t_second_line;
        run_chain(1'b1, 3, 40);          // R9 restart after load
        repeat (4) @(posedge clk);
        #1;
        check({a_lo, a_ro} == 2'b0, "R9", "idle after load, no spurious token",
              {a_lo, a_ro}, 0);
    endtask

    initial begin
        t_reset();
        t_fill_up();
        t_fill_down_restart_pulse();
        t_second_line();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule